// File: doc/BRIEF.md
# NCO Nanosecond Time Counter

This block keeps a 44-bit count of nanoseconds for a precision time protocol clock. A numerically controlled oscillator drives the count. On every clock cycle the oscillator adds a programmable 32-bit fixed-point step to a 72-bit accumulator. The upper 44 bits of the accumulator are whole nanoseconds. The lower 28 bits are fractions of a nanosecond, so one step LSB is worth 2^-28 ns. A step of 0x80000000 gives 8 ns per cycle, which suits a 125 MHz clock. Software trims the rate by nudging the step around that value.

Software reaches the block through four 32-bit words, selected by a 2-bit word index (the byte offset divided by four). The time splits into three fields: a 4-bit low field, a 32-bit middle word and an 8-bit top byte. To load a new time, software writes the low word, then the middle word, then the top word. The first two writes only fill holding registers. The top write commits all three fields to the accumulator at once and clears the fraction.

Reading the top byte also freezes a copy of the whole time. The next read of the middle word returns that copy, so a top/middle pair stays coherent even when a carry crosses between them. Bits [43:32] act as a 12-bit rollover indicator that wraps together with the count.

Top module: `nco_timebase`

## Requirements
- R1: Word index 0 reads time bits [3:0] in rdata[3:0]. Index 1 reads time bits [35:4] as a full word. Index 2 reads time bits [43:36] in rdata[7:0]. Index 3 reads the 32-bit step. Unused rdata bits read 0. rdata is registered and is valid after the clock edge at which rd_en is sampled high. It reflects the state just before that edge.
- R2: Reset clears the time, the fraction and the step, so the counter stays stopped and every word reads 0 until software writes a step.
- R3: On each clock edge the 72-bit accumulator {time, fraction} grows by the step. The step is weighted 2^-28 ns per LSB, and carries out of the 28-bit fraction reach the nanosecond field. A step of 0x80000000 adds exactly 8 ns per cycle.
- R4: A write to index 3 sets the step used from the next edge on. A step of 0 holds the time and fraction unchanged. Writing a nonzero step afterwards resumes counting from the held value.
- R5: Writing index 0 stores wdata[3:0], and writing index 1 stores wdata[31:0], as pending low and middle fields. Neither write changes the running time.
- R6: Writing index 2 takes the new top byte from wdata[15:8] and ignores wdata[7:0]. In the same edge it loads the time with {top byte, pending middle, pending low} and clears the fraction.
- R7: A read of index 2 captures the full time. The first read of index 1 after it returns the captured middle field. Later reads of index 1 return the live value until the next read of index 2.
- R8: After 0xFFFFFFFFFFF the time wraps to 0 modulo 2^44, and the rollover indicator in bits [43:32] wraps with it.
- R9: The step written to index 3 reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the time advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected word |
| rd_en | input | 1 | Read strobe for the selected word |
| addr | input | 2 | Word index: 0 low, 1 middle, 2 top, 3 step |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
Most faults in the accumulator or the step register reach the ports quickly. Any read of the low field within a cycle or two shows a wrong count of whole nanoseconds, and a wrongly held step shows in the freeze-and-resume sequence. A fraction that is not cleared at load shows up more slowly, after as many cycles as it takes the leftover fraction to carry. The sweeps use steps just below and just above one nanosecond so that this happens within a few reads. Faults in the holding registers or the capture register stay hidden until the next load or the next middle read after a top read. The bench therefore places each such read directly after the event that should change it.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    WSEL_LOW = 2'd0,
    WSEL_MID = 2'd1,
    WSEL_TOP = 2'd2,
    WSEL_INC = 2'd3
  } wsel_e;
endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int NS_W   = 44,
  parameter int FRAC_W = 28,
  parameter int INC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  step,
  input  logic              commit,
  input  logic [NS_W-1:0]   load_ns,
  output logic [NS_W-1:0]   time_ns,
  output logic [FRAC_W-1:0] frac_q
);
  localparam int ACC_W = NS_W + FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;

  // Fixed-point add: step is zero-extended, carry ripples into whole ns.
  function automatic logic [ACC_W-1:0] advance(input logic [ACC_W-1:0] acc,
                                               input logic [INC_W-1:0] inc);
    return acc + ACC_W'(inc);
  endfunction

  always_comb begin
    if (commit) acc_next = {load_ns, {FRAC_W{1'b0}}};
    else        acc_next = advance(acc_q, step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_next;
  end

  assign time_ns = acc_q[ACC_W-1:FRAC_W];
  assign frac_q  = acc_q[FRAC_W-1:0];
endmodule

// File: rtl/nco_regif.sv
module nco_regif
  import nco_pkg::*;
#(
  parameter int NS_W  = 44,
  parameter int LOW_W = 4,
  parameter int TOP_W = 8,
  parameter int INC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NS_W-1:0]   time_ns,
  output logic [DATA_W-1:0] rdata,
  output logic [INC_W-1:0]  step_q,
  output logic              commit,
  output logic [NS_W-1:0]   load_ns,
  output logic              snap_pending,
  output logic [NS_W-1:0]   snap_ns
);
  localparam int MID_W = NS_W - LOW_W - TOP_W;

  wsel_e             sel;
  logic [LOW_W-1:0]  pend_low;
  logic [MID_W-1:0]  pend_mid;
  logic [DATA_W-1:0] rd_word;
  logic              rd_top, rd_mid;

  assign sel    = wsel_e'(addr);
  assign commit = wr_en && (sel == WSEL_TOP);
  assign rd_top = rd_en && (sel == WSEL_TOP);
  assign rd_mid = rd_en && (sel == WSEL_MID);
  // The top byte sits one byte up on the write side.
  assign load_ns = {wdata[TOP_W +: TOP_W], pend_mid, pend_low};

  function automatic logic [DATA_W-1:0] pick_word(
    input wsel_e            s,
    input logic [NS_W-1:0]  t,
    input logic [NS_W-1:0]  snap,
    input logic             pend,
    input logic [INC_W-1:0] inc);
    case (s)
      WSEL_LOW: return DATA_W'(t[LOW_W-1:0]);
      WSEL_MID: return pend ? DATA_W'(snap[LOW_W +: MID_W])
                            : DATA_W'(t[LOW_W +: MID_W]);
      WSEL_TOP: return DATA_W'(t[NS_W-1 -: TOP_W]);
      default:  return DATA_W'(inc);
    endcase
  endfunction

  assign rd_word = pick_word(sel, time_ns, snap_ns, snap_pending, step_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_low <= '0;
      pend_mid <= '0;
      step_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        WSEL_LOW: pend_low <= wdata[LOW_W-1:0];
        WSEL_MID: pend_mid <= wdata[MID_W-1:0];
        WSEL_INC: step_q   <= wdata[INC_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_pending <= 1'b0;
      snap_ns      <= '0;
    end else if (rd_top) begin
      snap_pending <= 1'b1;
      snap_ns      <= time_ns;
    end else if (rd_mid) begin
      snap_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/nco_timebase.sv
module nco_timebase
  import nco_pkg::*;
#(
  parameter int NS_W   = 44,
  parameter int FRAC_W = 28,
  parameter int INC_W  = 32,
  parameter int LOW_W  = 4,
  parameter int TOP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  // Named internal events, visible to the bound checker.
  logic [NS_W-1:0]   time_ns;
  logic [FRAC_W-1:0] frac_q;
  logic [INC_W-1:0]  step_q;
  logic              commit_ev;
  logic [NS_W-1:0]   load_ns;
  logic              snap_pending;
  logic [NS_W-1:0]   snap_ns;

  nco_regif #(
    .NS_W(NS_W), .LOW_W(LOW_W), .TOP_W(TOP_W), .INC_W(INC_W)
  ) regif_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .time_ns(time_ns), .rdata(rdata),
    .step_q(step_q), .commit(commit_ev), .load_ns(load_ns),
    .snap_pending(snap_pending), .snap_ns(snap_ns)
  );

  nco_accum #(
    .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W)
  ) accum_i (
    .clk(clk), .rst_n(rst_n), .step(step_q), .commit(commit_ev),
    .load_ns(load_ns), .time_ns(time_ns), .frac_q(frac_q)
  );
endmodule

// File: rtl/nco_timebase_chk.sv
module nco_timebase_chk
  import nco_pkg::*;
#(
  parameter int NS_W   = 44,
  parameter int FRAC_W = 28,
  parameter int INC_W  = 32,
  parameter int TOP_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [SEL_W-1:0]  addr,
  input logic [DATA_W-1:0] rdata,
  input logic [NS_W-1:0]   time_ns,
  input logic [FRAC_W-1:0] frac_q,
  input logic [INC_W-1:0]  step_q,
  input logic              commit_ev,
  input logic [NS_W-1:0]   load_ns,
  input logic              snap_pending,
  input logic [NS_W-1:0]   snap_ns
);
  logic [NS_W-1:0]  prev_ns;
  logic [INC_W-1:0] prev_step;
  logic             prev_commit, prev_ok;
  logic [NS_W-1:0]  step_ns, max_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ns <= '0; prev_step <= '0; prev_commit <= 1'b0; prev_ok <= 1'b0;
    end else begin
      prev_ns <= time_ns; prev_step <= step_q;
      prev_commit <= commit_ev; prev_ok <= 1'b1;
    end
  end

  assign step_ns  = time_ns - prev_ns;
  assign max_step = NS_W'(prev_step >> FRAC_W) + NS_W'(1);

  // R6: a commit loads the pending fields and clears the fraction
  a_r6_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> (time_ns == $past(load_ns)) && (frac_q == '0));

  // R4: a zero step freezes the accumulator
  a_r4_zero_step_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_ev && step_q == '0) |=> ($stable(time_ns) && $stable(frac_q)));

  // R3: one cycle never advances more than the whole-ns part of the step plus a carry
  a_r3_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && !prev_commit) |-> (step_ns <= max_step));

  // R7: a top read captures the time and arms the snapshot
  a_r7_snapshot_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2) |=> (snap_pending && snap_ns == $past(time_ns)));

  // R7: a middle read consumes the snapshot
  a_r7_snapshot_used: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd1) |=> !snap_pending);

  // R1: the top word carries only the byte in its low bits
  a_r1_top_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2) |=> (rdata[DATA_W-1:TOP_W] == '0));
endmodule

bind nco_timebase nco_timebase_chk #(
  .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W), .TOP_W(TOP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .time_ns(time_ns), .frac_q(frac_q), .step_q(step_q),
  .commit_ev(commit_ev), .load_ns(load_ns),
  .snap_pending(snap_pending), .snap_ns(snap_ns)
);

// File: tb/nco_timebase_tb_top.sv
module nco_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  nco_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [43:0] exp_ns(input logic [43:0] t, input logic [31:0] inc, input int k);
    logic [63:0] whole;
    whole = (64'(k) * 64'(inc)) >> 28;
    return t + whole[43:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Called at a negedge; the transaction occupies the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output int edge_n);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    edge_n = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int r, r_top, t0, w, w2;
    logic [43:0] e, e_top, v;
    logic [31:0] inc;
    logic [7:0]  top;
    logic [31:0] mid;
    logic [3:0]  low;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R2: everything zero, counter stopped
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d, r);
      chk("R2 reset word", 64'(d), 64'd0);
    end
    idle(10);
    rd(2'd0, d, r); chk("R2 stopped low", 64'(d), 64'd0);
    rd(2'd1, d, r); chk("R2 stopped mid", 64'(d), 64'd0);

    // Sweep of steps and start times (R1 R3 R5 R6 R7 R8 R9)
    for (int c = 0; c < 7; c++) begin
      case (c)
        0: begin inc = 32'h8000_0000; top = 8'hFF; mid = 32'hFFFF_FFF0; low = 4'h8; end
        1: begin inc = 32'h1800_0000; top = 8'h12; mid = 32'hFFFF_FFFE; low = 4'h0; end
        2: begin inc = 32'h0FFF_FFFF; top = 8'h00; mid = 32'h0000_0000; low = 4'hA; end
        3: begin inc = 32'h1000_0001; top = 8'h7F; mid = 32'h0FFF_FFFF; low = 4'hF; end
        4: begin inc = 32'h0000_0000; top = 8'h3C; mid = 32'h1234_5678; low = 4'h9; end
        5: begin inc = 32'hFFFF_FFFF; top = 8'hFF; mid = 32'hFFFF_FFFF; low = 4'h0; end
        default: begin inc = 32'h0000_0007; top = 8'h01; mid = 32'hABCD_EF01; low = 4'h5; end
      endcase
      rd(2'd1, d, r);                 // drop any armed snapshot
      wr(2'd3, inc);
      wr(2'd0, {28'h0, low});
      wr(2'd1, mid);
      wr(2'd2, {16'h0, top, 8'h5A});  // R6: low byte is junk
      t0 = cyc;
      for (int j = 0; j < 8; j++) begin
        rd(2'd2, d, r_top);
        e_top = exp_ns({top, mid, low}, inc, r_top - 1 - t0);
        chk("R1 R8 top byte", 64'(d), 64'(e_top[43:36]));
        rd(2'd0, d, r);
        e = exp_ns({top, mid, low}, inc, r - 1 - t0);
        chk("R3 low field", 64'(d), 64'(e[3:0]));
        rd(2'd1, d, r);
        chk("R7 snapshot mid", 64'(d), 64'(e_top[35:4]));
        rd(2'd1, d, r);
        e = exp_ns({top, mid, low}, inc, r - 1 - t0);
        chk("R7 R8 live mid", 64'(d), 64'(e[35:4]));
        rd(2'd3, d, r);
        chk("R9 step readback", 64'(d), 64'(inc));
        if (j == 3) begin
          wr(2'd1, 32'hDEAD_BEEF);    // R5: pending only, time unaffected
          wr(2'd0, 32'h0000_0003);
        end
        idle(j * 13);
      end
    end

    // R4: freeze and resume
    rd(2'd1, d, r);
    wr(2'd3, 32'h8000_0000);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0000_0100);
    wr(2'd2, 32'h0000_0000);
    t0 = cyc;
    idle(5);
    wr(2'd3, 32'h0);
    w = cyc;
    v = exp_ns(44'h0000_0001_000, 32'h8000_0000, w - t0);
    idle(7);
    rd(2'd2, d, r); chk("R4 frozen top", 64'(d), 64'(v[43:36]));
    rd(2'd0, d, r); chk("R4 frozen low", 64'(d), 64'(v[3:0]));
    rd(2'd1, d, r); chk("R4 frozen mid", 64'(d), 64'(v[35:4]));
    idle(20);
    rd(2'd1, d, r); chk("R4 still frozen", 64'(d), 64'(v[35:4]));
    wr(2'd3, 32'h3000_0000);
    w2 = cyc;
    idle(4);
    rd(2'd1, d, r);
    e = exp_ns(v, 32'h3000_0000, r - 1 - w2);
    chk("R4 resumed mid", 64'(d), 64'(e[35:4]));
    rd(2'd0, d, r);
    e = exp_ns(v, 32'h3000_0000, r - 1 - w2);
    chk("R4 resumed low", 64'(d), 64'(e[3:0]));

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule